// File: doc/BRIEF.md
# Response Packet Framer

The framer wraps a block of 16-bit payload words (status words, pixel matrix readout and the like) into one response packet for the host link. A packet is opened with a one-cycle start request that carries the payload length. The framer then emits a start marker and a header word. The header holds a per-packet sequence number and the length. The payload words follow, taken from an upstream source over a valid/ready handshake. A CRC word and an end marker close the packet. Serialization, line coding and output buffering sit downstream of the 16-bit valid/ready output and are not part of this block.

Control uses only two states, idle and sending. Inside the sending state a phase register steps through marker, header, payload, CRC and marker. A payload counter ends the payload phase. The CRC register is seeded when a request is accepted and folds in each header and payload word as it leaves. The trailer therefore needs no extra cycle. When a packet closes, the framer signals completion for one cycle and can accept the next request in that same cycle.

Top module: `resp_framer`

## Requirements
- R1: Every packet is a run of 16-bit words in this order: start marker 16'hFB5C, header, the payload words in arrival order, CRC word, end marker 16'hFD5C.
- R2: The header word carries the packet sequence number in bits [15:8] and the payload length in bits [7:0].
- R3: The sequence number is 0 for the first packet after reset, rises by one per completed packet, and wraps from 255 to 0.
- R4: The CRC word is a CRC-16 with polynomial 0x1021 and seed 0xFFFF. It is fed most significant bit first, with no reflection and no final inversion, over the header word and then every payload word.
- R5: A request with length 0 yields a packet in which the CRC word follows the header directly, and no payload word is requested.
- R6: While out_valid_o is high and out_ready_i is low, the presented word stays unchanged and the packet does not advance.
- R7: pay_ready_o is high only while the framer is in the payload phase and out_ready_i is high. Each payload word is forwarded with its own valid.
- R8: A start request is taken only while idle. A request raised during a packet has no effect on that packet or on the next header.
- R9: done_o is high for exactly the one cycle after the end marker handshake. In that cycle the framer is idle and accepts a new request.
- R10: After reset, out_valid_o, pay_ready_o and done_o are low.
- R11: The start marker is presented with out_valid_o high in the cycle right after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to frame one packet |
| start_len_i | input | 8 | Payload length for the request |
| pay_data_i | input | 16 | Payload word from source |
| pay_valid_i | input | 1 | Payload word valid |
| pay_ready_o | output | 1 | Framer takes the payload word |
| out_data_o | output | 16 | Packet word toward host |
| out_valid_o | output | 1 | Packet word valid |
| out_ready_i | input | 1 | Downstream accepts the word |
| done_o | output | 1 | One-cycle pulse after end marker |

## Verification
Completion of one packet and acceptance of the next request can land in the same cycle. The bench provokes this by issuing each new request on the first cycle after the end marker handshake, when done_o is still high. It then expects the new start marker one cycle later and a header whose sequence number has moved on by exactly one. A downstream stall can also fall on the same cycle as a payload offer, or as a stray request mid-packet. Random backpressure and random source gaps are mixed with such stray requests. Every output word is compared with a packet image, including the CRC, that the bench computes on its own.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [WORD_W-1:0] CRC_SEED = 16'hFFFF;

  typedef enum logic { ST_IDLE, ST_SEND } st_e;
  typedef enum logic [2:0] { PH_SOP, PH_HDR, PH_PAY, PH_CRC, PH_EOP } ph_e;

  // Fold one word into the CRC, most significant bit first.
  function automatic logic [WORD_W-1:0] crc_step(input logic [WORD_W-1:0] c,
                                                  input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    logic fb;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[WORD_W-1] ^ d[i];
      r  = {r[WORD_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/rfr_crc.sv
module rfr_crc
  import rfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_i,
  input  logic              fold_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] crc_o
);
  logic [WORD_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (seed_i) crc_q <= CRC_SEED;
    else if (fold_i) crc_q <= crc_step(crc_q, word_i);
  end

  assign crc_o = crc_q;

  // R4: a fresh packet always starts from the seed
  a_r4_seed_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    seed_i |=> (crc_o == CRC_SEED));
endmodule

// File: rtl/rfr_ctrl.sv
module rfr_ctrl
  import rfr_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             pay_valid_i,
  input  logic             out_ready_i,
  output st_e              state_o,
  output ph_e              phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LEN_W-1:0] len_o,
  output logic             out_valid_o,
  output logic             fire_o,
  output logic             start_fire_o,
  output logic             done_o
);
  localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};
  localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  st_e              state_q;
  ph_e              phase_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             last_pay;
  logic             eop_fire;

  assign start_fire_o = (state_q == ST_IDLE) && start_i;
  assign out_valid_o  = (state_q == ST_SEND) && ((phase_q != PH_PAY) || pay_valid_i);
  assign fire_o       = out_valid_o && out_ready_i;
  assign last_pay     = (cnt_q + LEN_ONE) == len_q;
  assign eop_fire     = fire_o && (phase_q == PH_EOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_SOP;
      len_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_fire_o) begin
        state_q <= ST_SEND;
        phase_q <= PH_SOP;
        len_q   <= len_i;
        cnt_q   <= '0;
      end else if (fire_o) begin
        case (phase_q)
          PH_SOP: phase_q <= PH_HDR;
          PH_HDR: phase_q <= (len_q == '0) ? PH_CRC : PH_PAY;
          PH_PAY: begin
            cnt_q <= cnt_q + LEN_ONE;
            if (last_pay) phase_q <= PH_CRC;
          end
          PH_CRC: phase_q <= PH_EOP;
          PH_EOP: begin
            state_q <= ST_IDLE;
            phase_q <= PH_SOP;
            idx_q   <= idx_q + IDX_ONE;
            done_q  <= 1'b1;
          end
          default: phase_q <= PH_SOP;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign phase_o = phase_q;
  assign idx_o   = idx_q;
  assign len_o   = len_q;
  assign done_o  = done_q;

  // R9: completion pulse follows the end marker and lasts one cycle
  a_r9_done_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    eop_fire |=> (done_o && state_o == ST_IDLE));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R3: sequence number steps by one per packet
  a_r3_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    eop_fire |=> (idx_o == IDX_W'($past(idx_o) + IDX_ONE)));
  // R8: a request during a packet leaves the latched length alone
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_SEND && start_i) |=> (len_o == $past(len_o)));
  // R5: empty payload goes from header straight to CRC
  a_r5_zero_len_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && phase_o == PH_HDR && len_o == '0) |=> (phase_o == PH_CRC));
endmodule

// File: rtl/resp_framer.sv
module resp_framer
  import rfr_pkg::*;
#(
  parameter int              IDX_W    = 8,
  parameter int              LEN_W    = 8,
  parameter logic [15:0]     SOP_WORD = 16'hFB5C,
  parameter logic [15:0]     EOP_WORD = 16'hFD5C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] start_len_i,
  input  logic [15:0]      pay_data_i,
  input  logic             pay_valid_i,
  output logic             pay_ready_o,
  output logic [15:0]      out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             done_o
);
  st_e              state;
  ph_e              phase;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] len;
  logic             fire;
  logic             start_fire;
  logic             crc_fold;
  logic [15:0]      crc;
  logic [15:0]      hdr_word;

  rfr_ctrl #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .len_i        (start_len_i),
    .pay_valid_i  (pay_valid_i),
    .out_ready_i  (out_ready_i),
    .state_o      (state),
    .phase_o      (phase),
    .idx_o        (idx),
    .len_o        (len),
    .out_valid_o  (out_valid_o),
    .fire_o       (fire),
    .start_fire_o (start_fire),
    .done_o       (done_o)
  );

  assign hdr_word = {idx, len};
  assign crc_fold = fire && ((phase == PH_HDR) || (phase == PH_PAY));

  rfr_crc u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .seed_i (start_fire),
    .fold_i (crc_fold),
    .word_i (out_data_o),
    .crc_o  (crc)
  );

  always_comb begin
    case (phase)
      PH_SOP:  out_data_o = SOP_WORD;
      PH_HDR:  out_data_o = hdr_word;
      PH_PAY:  out_data_o = pay_data_i;
      PH_CRC:  out_data_o = crc;
      PH_EOP:  out_data_o = EOP_WORD;
      default: out_data_o = SOP_WORD;
    endcase
  end

  assign pay_ready_o = (state == ST_SEND) && (phase == PH_PAY) && out_ready_i;

  // R6: framer-generated words hold under backpressure
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && phase != PH_PAY) |=> (out_valid_o && $stable(out_data_o)));
  // R7: source is asked only while sending
  a_r7_pay_ready_in_send: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready_o |-> (state == ST_SEND && out_ready_i));
  // R11: start marker presented right after acceptance
  a_r11_sop_first: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> (out_valid_o && out_data_o == SOP_WORD));
  // R10: nothing offered while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!out_valid_o && !pay_ready_o));
endmodule

// File: tb/sim_resp_framer.sv
module sim_resp_framer;
  localparam int CLK_P = 10;
  localparam logic [15:0] SOP_W = 16'hFB5C;
  localparam logic [15:0] EOP_W = 16'hFD5C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  start_len_i = '0;
  logic [15:0] pay_data_i = '0;
  logic        pay_valid_i = 1'b0;
  logic        pay_ready_o;
  logic [15:0] out_data_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic        done_o;

  int   n_chk = 0;
  int   n_fail = 0;
  logic [7:0] exp_idx = '0;
  bit   done_exp = 1'b0;
  logic [15:0] pay_mem [0:255];

  always #(CLK_P/2) clk = ~clk;

  resp_framer u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_len_i(start_len_i),
    .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .done_o(done_o)
  );

  // Bench-side CRC: shift data and register together, compare top bits.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    logic [15:0] s = d;
    for (int b = 0; b < 16; b++) begin
      logic top;
      top = r[15] ^ s[15];
      r = r << 1;
      s = s << 1;
      if (top) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_pkt(input int len, input int stall_pct, input bit stray);
    logic [15:0] exp_w [0:259];
    logic [15:0] c;
    int n_exp, rec, pidx, it;
    bit prev_stall, finished, pv;
    logic [15:0] prev_word;
    for (int i = 0; i < len; i++) pay_mem[i] = 16'($urandom);
    exp_w[0] = SOP_W;
    exp_w[1] = {exp_idx, 8'(len)};
    c = ref_crc(16'hFFFF, exp_w[1]);
    for (int i = 0; i < len; i++) begin
      exp_w[2+i] = pay_mem[i];
      c = ref_crc(c, pay_mem[i]);
    end
    exp_w[len+2] = c;
    exp_w[len+3] = EOP_W;
    n_exp = len + 4;
    rec = 0; pidx = 0; it = 0; prev_stall = 0; finished = 0; pv = 0; prev_word = '0;
    while (!finished) begin
      @(negedge clk);
      if (it == 0) begin
        start_i = 1'b1;
        start_len_i = 8'(len);
      end else begin
        start_i = stray && ($urandom_range(0, 3) == 0);
        start_len_i = 8'hAA;
      end
      out_ready_i = ($urandom_range(0, 99) >= stall_pct);
      if (!pv) pv = ($urandom_range(0, 9) < 7);
      pay_valid_i = pv;
      pay_data_i = (pidx < len) ? pay_mem[pidx] : 16'h0;
      #1;
      if (it == 0) begin
        chk(done_o == done_exp, "R9 done pulse / back-to-back", {15'b0, done_o}, {15'b0, done_exp});
        chk(!out_valid_o, "R8 idle before start", {15'b0, out_valid_o}, 16'h0);
      end else begin
        chk(!done_o, "R9 done low mid-packet", {15'b0, done_o}, 16'h0);
      end
      if (it == 1)
        chk(out_valid_o && out_data_o == SOP_W, "R11 start marker next cycle", out_data_o, SOP_W);
      if (prev_stall)
        chk(out_valid_o && out_data_o == prev_word, "R6 hold under stall", out_data_o, prev_word);
      chk(pay_ready_o == ((it > 0) && rec >= 2 && rec < 2 + len && out_ready_i),
          "R7 payload ready window", {15'b0, pay_ready_o}, 16'h0);
      if (out_valid_o && out_ready_i) begin
        if (rec == 1)
          chk(out_data_o == exp_w[rec], "R2 R3 header index/length", out_data_o, exp_w[rec]);
        else if (rec == len + 2)
          chk(out_data_o == exp_w[rec], (len == 0) ? "R5 R4 crc after header" : "R4 crc word",
              out_data_o, exp_w[rec]);
        else
          chk(out_data_o == exp_w[rec], "R1 packet word", out_data_o, exp_w[rec]);
        rec++;
        if (rec == n_exp) finished = 1;
      end
      if (pay_ready_o && pay_valid_i) begin
        pidx++;
        pv = 0;
      end
      prev_stall = out_valid_o && !out_ready_i;
      prev_word = out_data_o;
      it++;
      if (it > 5000) begin
        chk(1'b0, "R1 packet stalled", 16'(rec), 16'(n_exp));
        finished = 1;
      end
    end
    exp_idx = exp_idx + 8'd1;
    done_exp = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid_o && !pay_ready_o && !done_o, "R10 reset outputs quiet",
        {13'b0, out_valid_o, pay_ready_o, done_o}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid_o && !pay_ready_o && !done_o, "R10 after reset release",
        {13'b0, out_valid_o, pay_ready_o, done_o}, 16'h0);
    // directed corners: empty, single, full length, heavy stall with stray requests
    run_pkt(0, 0, 1'b0);
    run_pkt(1, 0, 1'b0);
    run_pkt(255, 20, 1'b1);
    run_pkt(5, 80, 1'b1);
    // random mix, enough packets to wrap the sequence number (R3)
    for (int p = 0; p < 256; p++)
      run_pkt($urandom_range(0, 7), $urandom_range(0, 60), $urandom_range(0, 1));
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(done_o == 1'b1, "R9 final done pulse", {15'b0, done_o}, 16'h1);
    chk(!out_valid_o, "R8 no packet without request", {15'b0, out_valid_o}, 16'h0);
    @(negedge clk);
    #1;
    chk(!done_o && !out_valid_o, "R9 pulse is one cycle", {14'b0, done_o, out_valid_o}, 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule